// File: doc/BRIEF.md
# Reset Sequencer with Bus Clock Startup

This block collects reset requests for a small microcontroller and turns them into one internal reset, a drive-low command for the bidirectional reset pad, a gated bus clock and a record of why the last reset happened. The sources are power-on, supply-low detection, an undefined opcode, an access to an undecoded address, the watchdog and the external reset pin.

Power-on and supply-low events open a long window of `LONG_CYCLES` input clock edges. During that window the bus clock is held low and the pad is pulled low. Every other source opens a short window of `SHORT_CYCLES` edges, and the bus clock keeps running through it. When either window closes, the pad is released at once. The internal reset stays high for one more bus period, so logic sees clock edges before it leaves reset.

The bus clock is the incoming clock-generator output divided by two. It comes from a register, so it never glitches. A six-bit one-hot cause register names the source of the window that is running or last ran.

Top module: `rst_clk_seq`

## Requirements
- R1: While `por_i` is high, and for exactly `LONG_CYCLES` (default 4096) rising edges of `clk_i` after it falls, `pin_drive_lo_o` and `sys_rst_o` are 1; afterwards `cause_o` is 6'b000001 (bit 0 = power-on).
- R2: `lvi_i` sampled high outside a long window opens a long window. While a long window is open, every edge with `lvi_i` high restarts it, so the pad is released on the `LONG_CYCLES`-th edge after the last edge with `lvi_i` high.
- R3: `bus_clk_o` is 0 at every sample taken while a long window is open.
- R4: When no long window is open, `bus_clk_o` changes level on every rising edge of `clk_i` (divide by two), and it only changes on those edges.
- R5: A watchdog, undefined-opcode, bad-address or pin request (`pin_rst_n_i` low) sampled while the block runs opens a short window of exactly `SHORT_CYCLES` (default 32) edges with the pad driven low.
- R6: When requests arrive in the same cycle, the winner is chosen in this order: supply-low, watchdog, undefined opcode, bad address, pin. Only the winner's bit is set in `cause_o`. The bit positions are: 0 power-on, 1 supply-low, 2 watchdog, 3 undefined opcode, 4 bad address, 5 pin.
- R7: Watchdog, opcode, address and pin requests that arrive while a window is open or during the release period change neither `cause_o` nor the window length.
- R8: `sys_rst_o` falls exactly 2 `clk_i` edges (one bus period) after the edge on which `pin_drive_lo_o` falls.
- R9: `lvi_i` sampled high during a short window or during the release period turns it into a long window, and `cause_o` becomes 6'b000010.
- R10: `lvi_i` during a long window does not change `cause_o`. `cause_o` is always one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock-generator output; also the timeout time base |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| lvi_i | input | 1 | Supply-low detect, active high |
| ill_op_i | input | 1 | Undefined opcode request |
| ill_addr_i | input | 1 | Undecoded address request |
| wdog_i | input | 1 | Watchdog timeout request |
| pin_rst_n_i | input | 1 | Level seen on the reset pad, active low |
| pin_drive_lo_o | output | 1 | Pull the reset pad low |
| sys_rst_o | output | 1 | Internal reset to CPU and peripherals |
| bus_clk_o | output | 1 | Gated bus clock, `clk_i` divided by two |
| cause_o | output | 6 | One-hot reset cause register |

## Verification
Two collisions matter. Several requests can be sampled on the same edge, which puts the priority encoder against the cause register. A supply-low event can land inside a short window that is already running, which puts the long-window restart against short-window completion. The bench provokes same-edge collisions from its vector table, including supply-low together with the watchdog. It also raises supply-low a few edges into a watchdog window. Each case is judged by the total number of edges the pad stays low and by the cause bits read afterwards.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   typedef enum logic [1:0] {
      ST_LONG  = 2'd0,
      ST_SHORT = 2'd1,
      ST_REL   = 2'd2,
      ST_RUN   = 2'd3
   } seq_state_t;

   // requester index order is the priority order (0 wins)
   localparam int REQ_LVI   = 0;
   localparam int REQ_WDOG  = 1;
   localparam int REQ_ILOP  = 2;
   localparam int REQ_ILAD  = 3;
   localparam int REQ_PIN   = 4;
   localparam int NUM_REQ   = 5;
   localparam int NUM_CAUSE = NUM_REQ + 1;
endpackage

// File: rtl/rcs_cause_arb.sv
module rcs_cause_arb #(
   parameter int N = 5
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);
   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_prio
      assign blocked[i+1] = blocked[i] | req_i[i];
      assign grant_o[i]   = req_i[i] & ~blocked[i];
   end

   assign any_o = blocked[N];

   always_comb begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R6
   end
endmodule

// File: rtl/rcs_timer.sv
module rcs_timer #(
   parameter int LIMIT = 4096,
   localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [CW-1:0] cnt_o
);
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)      cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
   end

   AST_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
      inc_i && !clr_i |=> cnt_o != '0); // R1
endmodule

// File: rtl/rcs_busclk.sv
module rcs_busclk (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   output logic bus_o
);
   logic bus_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)     bus_q <= 1'b0;
      else if (en_i) bus_q <= ~bus_q;
      else           bus_q <= 1'b0;
   end

   assign bus_o = bus_q;

   AST_GATED_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> !bus_o); // R3
   AST_DIV_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      en_i |=> bus_o != $past(bus_o)); // R4
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
   import rcs_pkg::*;
#(
   parameter int LONG_CYCLES  = 4096,
   parameter int SHORT_CYCLES = 32
) (
   input  logic                 clk_i,
   input  logic                 por_i,
   input  logic                 lvi_i,
   input  logic                 ill_op_i,
   input  logic                 ill_addr_i,
   input  logic                 wdog_i,
   input  logic                 pin_rst_n_i,
   output logic                 pin_drive_lo_o,
   output logic                 sys_rst_o,
   output logic                 bus_clk_o,
   output logic [NUM_CAUSE-1:0] cause_o
);
   localparam int REL_CYCLES = 2;
   localparam int CW = $clog2(LONG_CYCLES);

   if (SHORT_CYCLES < 2 || SHORT_CYCLES >= LONG_CYCLES) begin : g_bad_len
      $error("rst_clk_seq: need 2 <= SHORT_CYCLES < LONG_CYCLES");
   end
   if (LONG_CYCLES < 4) begin : g_bad_long
      $error("rst_clk_seq: LONG_CYCLES too small");
   end

   seq_state_t           state_q, state_d;
   logic [NUM_CAUSE-1:0] cause_q, cause_d;
   logic [NUM_REQ-1:0]   req, grant;
   logic                 any_req, tmr_clr;
   logic [CW-1:0]        cnt;

   assign req[REQ_LVI]  = lvi_i;
   assign req[REQ_WDOG] = wdog_i;
   assign req[REQ_ILOP] = ill_op_i;
   assign req[REQ_ILAD] = ill_addr_i;
   assign req[REQ_PIN]  = ~pin_rst_n_i;

   rcs_cause_arb #(.N(NUM_REQ)) arb_i (
      .req_i   (req),
      .grant_o (grant),
      .any_o   (any_req)
   );

   rcs_timer #(.LIMIT(LONG_CYCLES)) tmr_i (
      .clk_i (clk_i),
      .rst_i (por_i),
      .clr_i (tmr_clr),
      .inc_i (state_q != ST_RUN),
      .cnt_o (cnt)
   );

   always_comb begin
      state_d = state_q;
      cause_d = cause_q;
      unique case (state_q)
         ST_RUN: if (any_req) begin
            state_d = grant[REQ_LVI] ? ST_LONG : ST_SHORT;
            cause_d = {grant, 1'b0};
         end
         ST_LONG: if (!lvi_i && cnt == CW'(LONG_CYCLES - 1)) state_d = ST_REL;
         ST_SHORT: if (lvi_i) begin
            state_d = ST_LONG;
            cause_d = NUM_CAUSE'(1) << (REQ_LVI + 1);
         end else if (cnt == CW'(SHORT_CYCLES - 1)) state_d = ST_REL;
         ST_REL: if (lvi_i) begin
            state_d = ST_LONG;
            cause_d = NUM_CAUSE'(1) << (REQ_LVI + 1);
         end else if (cnt == CW'(REL_CYCLES - 1)) state_d = ST_RUN;
         default: state_d = ST_LONG;
      endcase
   end

   assign tmr_clr = (state_d != state_q) || (state_q == ST_LONG && lvi_i);

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         state_q <= ST_LONG;
         cause_q <= NUM_CAUSE'(1);
      end else begin
         state_q <= state_d;
         cause_q <= cause_d;
      end
   end

   rcs_busclk bclk_i (
      .clk_i (clk_i),
      .rst_i (por_i),
      .en_i  (state_d != ST_LONG),
      .bus_o (bus_clk_o)
   );

   assign pin_drive_lo_o = (state_q == ST_LONG) || (state_q == ST_SHORT);
   assign sys_rst_o      = (state_q != ST_RUN);
   assign cause_o        = cause_q;

   AST_PIN_IMPLIES_RST: assert property (@(posedge clk_i) disable iff (por_i)
      pin_drive_lo_o |-> sys_rst_o); // R1
   AST_LONG_BUS_LOW: assert property (@(posedge clk_i) disable iff (por_i)
      state_q == ST_LONG |-> !bus_clk_o); // R3
   AST_CAUSE_ONEHOT: assert property (@(posedge clk_i) disable iff (por_i)
      $countones(cause_o) == 1); // R10
   AST_CAUSE_HELD: assert property (@(posedge clk_i) disable iff (por_i)
      state_q != ST_RUN && !lvi_i |=> $stable(cause_o)); // R7
   AST_LVI_NO_CAUSE: assert property (@(posedge clk_i) disable iff (por_i)
      state_q == ST_LONG |=> $stable(cause_o)); // R10
   AST_REL_GAP: assert property (@(posedge clk_i) disable iff (por_i)
      $fell(sys_rst_o) |-> !$past(pin_drive_lo_o) && !$past(pin_drive_lo_o, 2)); // R8
   AST_LVI_TO_LONG: assert property (@(posedge clk_i) disable iff (por_i)
      lvi_i |=> pin_drive_lo_o && !bus_clk_o); // R2
endmodule

// File: tb/rst_clk_seq_tb_top.sv
module rst_clk_seq_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LONG  = 4096;
   localparam int SHORT = 32;
   localparam int NV    = 7;
   // {req[4:0] = pin,illaddr,illop,wdog,lvi ; expected cause[5:0]}
   localparam logic [10:0] VEC [NV] = '{
      {5'b00010, 6'b000100},
      {5'b00100, 6'b001000},
      {5'b01000, 6'b010000},
      {5'b10000, 6'b100000},
      {5'b00110, 6'b000100},
      {5'b00011, 6'b000010},
      {5'b11100, 6'b001000}
   };

   logic clk = 1'b0;
   logic por = 1'b1, lvi = 1'b0, ilop = 1'b0, ilad = 1'b0, wdog = 1'b0, pin_n = 1'b1;
   logic pin_lo, srst, bclk;
   logic [5:0] cause;
   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   rst_clk_seq #(.LONG_CYCLES(LONG), .SHORT_CYCLES(SHORT)) dut_i (
      .clk_i(clk), .por_i(por), .lvi_i(lvi), .ill_op_i(ilop), .ill_addr_i(ilad),
      .wdog_i(wdog), .pin_rst_n_i(pin_n), .pin_drive_lo_o(pin_lo),
      .sys_rst_o(srst), .bus_clk_o(bclk), .cause_o(cause)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   // count edges until the pad is released; also count bus-high samples
   task automatic wait_pin(inout int n, output int bus_hi);
      bus_hi = 0;
      while (pin_lo && n < 3 * LONG) begin
         step(); n++;
         if (pin_lo && bclk) bus_hi++;
      end
   endtask

   task automatic wait_run(output int m);
      m = 0;
      while (srst && m < 100) begin step(); m++; end
   endtask

   task automatic drive(input logic [4:0] r);
      lvi = r[0]; wdog = r[1]; ilop = r[2]; ilad = r[3]; pin_n = ~r[4];
   endtask

   int n, m, bh;
   logic b0;

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) step();
      chk("R1 reset pin", pin_lo, 1);
      chk("R1 reset sys", srst, 1);
      chk("R3 reset bus", bclk, 0);
      por = 1'b0;
      n = 0; wait_pin(n, bh);
      chk("R1 por window", n, LONG);
      chk("R3 bus low in long", bh, 0);
      wait_run(m);
      chk("R8 release gap", m, 2);
      chk("R1 por cause", cause, 6'b000001);

      // R4 divide by two
      b0 = bclk; step();
      chk("R4 toggle a", bclk, !b0);
      step();
      chk("R4 toggle b", bclk, b0);

      // vector table: R5 R6 and LVI from run R2
      for (int v = 0; v < NV; v++) begin
         drive(VEC[v][10:6]);
         step();
         drive(5'b00000);
         n = 0; wait_pin(n, bh);
         chk($sformatf("R5/R2 window vec%0d", v), n, VEC[v][6] ? LONG : SHORT);
         wait_run(m);
         chk($sformatf("R8 gap vec%0d", v), m, 2);
         chk($sformatf("R6 cause vec%0d", v), cause, VEC[v][5:0]);
         step();
      end

      // R7: request inside a short window is ignored
      wdog = 1'b1; step(); wdog = 1'b0; n = 0;
      repeat (5) begin step(); n++; end
      ilop = 1'b1; step(); n++; ilop = 1'b0;
      chk("R7 cause mid window", cause, 6'b000100);
      wait_pin(n, bh);
      chk("R7 window unchanged", n, SHORT);
      wait_run(m);
      chk("R7 cause after", cause, 6'b000100);
      step();

      // R9: LVI inside a short window converts it
      wdog = 1'b1; step(); wdog = 1'b0; n = 0;
      repeat (5) begin step(); n++; end
      lvi = 1'b1; step(); n++; lvi = 1'b0;
      chk("R9 cause lvi", cause, 6'b000010);
      wait_pin(n, bh);
      chk("R9 long window", n, 6 + LONG);
      chk("R3 bus low after convert", bh, 0);
      wait_run(m);

      // R2 restart and R10 cause kept: LVI during a POR window
      por = 1'b1; step(); por = 1'b0;
      repeat (1000) step();
      lvi = 1'b1; repeat (3) step(); lvi = 1'b0;
      n = 0; wait_pin(n, bh);
      chk("R2 restart window", n, LONG);
      chk("R10 cause kept", cause, 6'b000001);
      wait_run(m);
      chk("R8 gap after restart", m, 2);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule